// File: doc/BRIEF.md
# Strobe-Driven FIFO Read Port

This block lets an external master pull words out of a small bank of internal FIFOs using four asynchronous, active-low controls: a chip select, a read strobe, an output enable and a FIFO select. The block runs on its own internal clock. All controls pass through multi-stage synchronizers. A qualified strobe is the chip select and the read strobe asserted together. The leading edge of a qualified strobe loads the selected FIFO's head word into an output register. The trailing edge of the strobe advances that FIFO's read pointer.

The output register reaches the shared data bus only while output enable is asserted. Output enable and the read strobe are separate controls. Asserting output enable alone therefore shows the word fetched by the previous read, and a strobe is needed to bring the current head word forward. The strobe's active and inactive widths are measured in internal clock cycles against programmable minimums. A pulse that breaks either minimum is refused and sets a sticky protocol-error output. Simple internal FIFO storage and a synchronous write port stand in for the producer side. Active-low empty and full flags describe the FIFO currently selected.

Top module: `sfr_read_port`

## Requirements
- R1: After reset the bus is not driven (`bus_drive`=0), the output register holds 0, `empty_n`=0, `full_n`=1 and `proto_err`=0.
- R2: The bus is driven (`bus_drive`=1) only while `oe_n` is low; with `oe_n` high it is released.
- R3: With `oe_n` low and no qualified strobe, the bus carries the word fetched by the most recent accepted read (0 if there has been none), and it keeps that word after the strobe is released.
- R4: A read needs both `cs_n` and `rd_n` low. A `rd_n` pulse with `cs_n` high neither changes the bus word nor moves the pointer.
- R5: An accepted strobe presents the selected FIFO's head word and advances the pointer when the strobe is released. Consecutive strobes return the words in write order.
- R6: A strobe while the selected FIFO is empty leaves the pointer and the bus word unchanged and raises no error.
- R7: A strobe active for fewer than MIN_ACT synchronized cycles does not advance the pointer, so the next read returns the same word, and it sets `proto_err`, which stays set until reset.
- R8: A strobe whose preceding inactive time is shorter than MIN_INACT cycles is ignored, with no fetch and no advance, and it sets `proto_err`.
- R9: `empty_n` is 0 exactly when the selected FIFO holds no word, and it falls in the cycle the last word is consumed. `full_n` is 0 exactly when the selected FIFO holds DEPTH words. A write to a full FIFO is dropped.
- R10: With `oe_n` and `rd_n` driven as one signal, each pulse shows the next word in order, and the bus is released between pulses.
- R11: `fifo_sel` picks the FIFO that is read and flagged. Each FIFO keeps its own pointers and count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| rd_n | input | 1 | Read strobe, active low, asynchronous |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| fifo_sel | input | FW | FIFO select, asynchronous, held stable around a read |
| wr_en | input | 1 | Write-model push enable |
| wr_sel | input | FW | FIFO targeted by the write |
| wr_data | input | DW | Word to write |
| data_io | inout | DW | Shared tri-state data bus |
| bus_drive | output | 1 | Pad drive enable for `data_io` |
| empty_n | output | 1 | Low when the selected FIFO is empty |
| full_n | output | 1 | Low when the selected FIFO is full |
| proto_err | output | 1 | Sticky strobe-width violation |

## Verification
Some properties are checked on every cycle. A pop never takes place on an empty FIFO, and no count ever goes past the depth. A pop happens only on a synchronized strobe release. The output word cannot change while chip select is inactive. The error bit never clears once set. Other behaviours can only be shown by the bench's scenarios, because each one spans a whole strobe sequence. These are the word returned after a refused short pulse or short gap, the old word held across an empty read, and the word order of bursts across both FIFOs, including in the tied-strobe mode.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
   // synchronized, active-high view of the external controls
   typedef struct packed {
      logic cs;
      logic rd;
      logic oe;
   } strobe_t;
endpackage

// File: rtl/sfr_sync.sv
module sfr_sync #(
   parameter int              W       = 1,
   parameter int              STAGES  = 2,
   parameter logic [W-1:0]    RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   initial begin : elab_chk
      assert (STAGES >= 2) else $error("sfr_sync: STAGES must be >= 2");
      assert (W >= 1) else $error("sfr_sync: W must be >= 1");
   end

   logic [STAGES-1:0][W-1:0] stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg <= {STAGES{RST_VAL}};
      end else begin
         stg[0] <= d;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/sfr_pulse_qual.sv
module sfr_pulse_qual #(
   parameter int  MIN_ACT   = 3,
   parameter int  MIN_INACT = 2,
   localparam int AW = $clog2(MIN_ACT + 1),
   localparam int IW = $clog2(MIN_INACT + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic strobe,     // synchronized qualified strobe
   input  logic allow,      // a word is available to fetch
   output logic rise_acc,
   output logic rise_rej,
   output logic fall_acc,
   output logic fall_rej
);
   initial begin : elab_chk
      assert (MIN_ACT >= 1) else $error("sfr_pulse_qual: MIN_ACT must be >= 1");
      assert (MIN_INACT >= 1) else $error("sfr_pulse_qual: MIN_INACT must be >= 1");
   end

   logic          strobe_d;
   logic [AW-1:0] act_cnt;
   logic [IW-1:0] idle_cnt;
   logic          armed;
   logic          rise, fall, act_ok, idle_ok;

   assign rise    = strobe & ~strobe_d;
   assign fall    = ~strobe & strobe_d;
   assign act_ok  = act_cnt >= AW'(MIN_ACT);
   assign idle_ok = idle_cnt >= IW'(MIN_INACT);

   assign rise_acc = rise & idle_ok & allow;
   assign rise_rej = rise & ~idle_ok;
   assign fall_acc = fall & armed & act_ok;
   assign fall_rej = fall & armed & ~act_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         strobe_d <= 1'b0;
         act_cnt  <= '0;
         idle_cnt <= IW'(MIN_INACT);
         armed    <= 1'b0;
      end else begin
         strobe_d <= strobe;
         if (!strobe)     act_cnt <= '0;
         else if (!act_ok) act_cnt <= act_cnt + 1'b1;
         if (strobe)       idle_cnt <= '0;
         else if (!idle_ok) idle_cnt <= idle_cnt + 1'b1;
         if (rise_acc)  armed <= 1'b1;
         else if (fall) armed <= 1'b0;
      end
   end

   // R8: a refused rise never arms the pointer advance
   a_r8_reject_not_armed: assert property (@(posedge clk) disable iff (!rst_n)
      rise_rej |=> !armed);
endmodule

// File: rtl/sfr_fifo_bank.sv
module sfr_fifo_bank #(
   parameter int  NF    = 2,
   parameter int  DW    = 8,
   parameter int  DEPTH = 4,
   localparam int FW = (NF > 1) ? $clog2(NF) : 1,
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_en,
   input  logic [FW-1:0]          wr_sel,
   input  logic [DW-1:0]          wr_data,
   input  logic                   pop,
   input  logic [FW-1:0]          pop_sel,
   output logic [NF-1:0][DW-1:0]  heads,
   output logic [NF-1:0][CW-1:0]  counts
);
   initial begin : elab_chk
      assert (DEPTH >= 2 && (DEPTH & (DEPTH - 1)) == 0)
         else $error("sfr_fifo_bank: DEPTH must be a power of two >= 2");
   end

   for (genvar g = 0; g < NF; g++) begin : g_fifo
      logic [DW-1:0] mem [DEPTH];
      logic [PW-1:0] wp, rp;
      logic [CW-1:0] cnt;
      logic          push_g, pop_g;

      assign push_g = wr_en && (wr_sel == FW'(g)) && (cnt != CW'(DEPTH));
      assign pop_g  = pop && (pop_sel == FW'(g)) && (cnt != '0);

      always_ff @(posedge clk) begin
         if (push_g) mem[wp] <= wr_data;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
         end else begin
            if (push_g) wp <= wp + 1'b1;
            if (pop_g)  rp <= rp + 1'b1;
            case ({push_g, pop_g})
               2'b10:   cnt <= cnt + 1'b1;
               2'b01:   cnt <= cnt - 1'b1;
               default: cnt <= cnt;
            endcase
         end
      end

      assign heads[g]  = mem[rp];
      assign counts[g] = cnt;

      // R6: the port never requests a pop from an empty FIFO
      a_r6_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
         (pop && pop_sel == FW'(g)) |-> (cnt != '0));
      // R9: occupancy bounded by the depth
      a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
         cnt <= CW'(DEPTH));
   end
endmodule

// File: rtl/sfr_read_port.sv
module sfr_read_port #(
   parameter int  NF          = 2,
   parameter int  DW          = 8,
   parameter int  DEPTH       = 4,
   parameter int  MIN_ACT     = 3,
   parameter int  MIN_INACT   = 2,
   parameter int  SYNC_STAGES = 2,
   localparam int FW = (NF > 1) ? $clog2(NF) : 1,
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cs_n,
   input  logic          rd_n,
   input  logic          oe_n,
   input  logic [FW-1:0] fifo_sel,
   input  logic          wr_en,
   input  logic [FW-1:0] wr_sel,
   input  logic [DW-1:0] wr_data,
   inout  wire  [DW-1:0] data_io,
   output logic          bus_drive,
   output logic          empty_n,
   output logic          full_n,
   output logic          proto_err
);
   import sfr_pkg::*;

   initial begin : elab_chk
      assert (NF >= 2 && NF == (1 << FW))
         else $error("sfr_read_port: NF must be a power of two >= 2");
   end

   logic [2:0]    raw_s;
   logic [FW-1:0] sel_s;
   strobe_t       strb;

   sfr_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b111)) u_sync_ctl (
      .clk(clk), .rst_n(rst_n), .d({cs_n, rd_n, oe_n}), .q(raw_s));
   sfr_sync #(.W(FW), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_sel (
      .clk(clk), .rst_n(rst_n), .d(fifo_sel), .q(sel_s));

   assign strb.cs = ~raw_s[2];
   assign strb.rd = ~raw_s[1];
   assign strb.oe = ~raw_s[0];

   logic                  qual_stb, sel_has_data;
   logic                  rise_acc, rise_rej, fall_acc, fall_rej;
   logic [NF-1:0][DW-1:0] heads;
   logic [NF-1:0][CW-1:0] counts;
   logic [DW-1:0]         out_reg;
   logic [FW-1:0]         sel_lat;
   logic                  err_q;

   assign qual_stb     = strb.cs & strb.rd;
   assign sel_has_data = counts[sel_s] != '0;

   sfr_pulse_qual #(.MIN_ACT(MIN_ACT), .MIN_INACT(MIN_INACT)) u_qual (
      .clk(clk), .rst_n(rst_n), .strobe(qual_stb), .allow(sel_has_data),
      .rise_acc(rise_acc), .rise_rej(rise_rej),
      .fall_acc(fall_acc), .fall_rej(fall_rej));

   sfr_fifo_bank #(.NF(NF), .DW(DW), .DEPTH(DEPTH)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .pop(fall_acc), .pop_sel(sel_lat),
      .heads(heads), .counts(counts));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_reg <= '0;
         sel_lat <= '0;
         err_q   <= 1'b0;
      end else begin
         if (rise_acc) begin
            out_reg <= heads[sel_s];
            sel_lat <= sel_s;
         end
         if (rise_rej || fall_rej) err_q <= 1'b1;
      end
   end

   assign bus_drive = strb.oe;
   assign data_io   = strb.oe ? out_reg : 'z;
   assign empty_n   = sel_has_data;
   assign full_n    = counts[sel_s] != CW'(DEPTH);
   assign proto_err = err_q;

   // R5: the pointer moves only on a synchronized strobe release
   a_r5_pop_on_release: assert property (@(posedge clk) disable iff (!rst_n)
      fall_acc |-> (!qual_stb && $past(qual_stb)));
   // R4: without chip select the output word cannot change
   a_r4_no_fetch_without_cs: assert property (@(posedge clk) disable iff (!rst_n)
      !strb.cs |=> $stable(out_reg));
   // R7: the error indication is sticky
   a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      err_q |=> err_q);
endmodule

// File: tb/sfr_read_port_tb.sv
module sfr_read_port_tb;
   localparam int NF = 2, DW = 8, DEPTH = 4;

   logic clk = 1'b0;
   always #10 clk = ~clk;   // 50 MHz

   logic          rst_n, cs_n, rd_n, oe_n, wr_en;
   logic [0:0]    fifo_sel, wr_sel;
   logic [DW-1:0] wr_data;
   wire  [DW-1:0] data_io;
   logic          bus_drive, empty_n, full_n, proto_err;

   sfr_read_port #(.NF(NF), .DW(DW), .DEPTH(DEPTH), .MIN_ACT(3), .MIN_INACT(2)) u_dut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .oe_n(oe_n),
      .fifo_sel(fifo_sel), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .data_io(data_io), .bus_drive(bus_drive), .empty_n(empty_n),
      .full_n(full_n), .proto_err(proto_err));

   int total = 0;
   int bad   = 0;

   task automatic chk(string tag, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_reset();
      rst_n = 1'b0; cs_n = 1'b1; rd_n = 1'b1; oe_n = 1'b1;
      wr_en = 1'b0; fifo_sel = '0; wr_sel = '0; wr_data = '0;
      tick(3);
      rst_n = 1'b1;
      tick(3);
   endtask

   task automatic push(int f, int d);
      wr_sel = 1'(f); wr_data = 8'(d); wr_en = 1'b1;
      tick(1);
      wr_en = 1'b0;
   endtask

   // strobe low for act cycles, then high for gap cycles; bus sampled mid-pulse
   task automatic pulse(int act, int gap, bit tied, output int seen);
      rd_n = 1'b0;
      if (tied) oe_n = 1'b0;
      if (act >= 5) begin
         tick(4);
         seen = int'(data_io);
         tick(act - 4);
      end else begin
         tick(act);
         seen = -1;
      end
      rd_n = 1'b1;
      if (tied) oe_n = 1'b1;
      tick(gap);
   endtask

   function automatic int val(int f, int k);
      return f * 64 + k * 7 + 3;
   endfunction

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      int w;
      do_reset();
      // R1 reset state
      chk("R1 bus_drive", int'(bus_drive), 0);
      chk("R1 empty_n", int'(empty_n), 0);
      chk("R1 full_n", int'(full_n), 1);
      chk("R1 proto_err", int'(proto_err), 0);

      // R3 / R2: output enable alone shows the reset word
      oe_n = 1'b0; tick(4);
      chk("R2 drive on oe", int'(bus_drive), 1);
      chk("R3 previous word after reset", int'(data_io), 0);
      oe_n = 1'b1; tick(4);
      chk("R2 released", int'(bus_drive), 0);

      // R5/R9/R11 sweep: fill both FIFOs, overfill, drain each
      for (int f = 0; f < NF; f++) begin
         for (int k = 0; k < DEPTH; k++) push(f, val(f, k));
         push(f, 8'hEE);  // dropped, FIFO full
      end
      for (int f = 0; f < NF; f++) begin
         fifo_sel = 1'(f); tick(4);
         chk("R9 full_n at depth", int'(full_n), 0);
         chk("R11 selected fifo not empty", int'(empty_n), 1);
         cs_n = 1'b0; oe_n = 1'b0; tick(3);
         for (int k = 0; k < DEPTH; k++) begin
            pulse(5, 5, 1'b0, w);
            chk("R5 burst word", w, val(f, k));
            chk("R3 held after release", int'(data_io), val(f, k));
            chk("R9 empty_n", int'(empty_n), (k < DEPTH - 1) ? 1 : 0);
            chk("R9 full_n after read", int'(full_n), 1);
         end
         pulse(5, 5, 1'b0, w);
         chk("R6 empty read keeps word", w, val(f, DEPTH - 1));
         chk("R6 still empty", int'(empty_n), 0);
         chk("R6 no error", int'(proto_err), 0);
         cs_n = 1'b1; oe_n = 1'b1; tick(4);
         chk("R2 released after burst", int'(bus_drive), 0);
      end

      // R4: strobe without chip select
      do_reset();
      push(0, 8'h11); push(0, 8'h22);
      oe_n = 1'b0; tick(3);
      pulse(5, 5, 1'b0, w);
      chk("R4 no fetch without cs", w, 0);
      chk("R4 pointer kept", int'(empty_n), 1);
      cs_n = 1'b0; tick(3);
      pulse(5, 5, 1'b0, w);
      chk("R4 first word intact", w, 8'h11);
      pulse(5, 5, 1'b0, w);
      chk("R4 second word", w, 8'h22);
      chk("R9 empty after last", int'(empty_n), 0);

      // R10: output enable tied to read strobe
      do_reset();
      push(0, 8'h31); push(0, 8'h32); push(0, 8'h33);
      cs_n = 1'b0; tick(3);
      for (int k = 0; k < 3; k++) begin
         pulse(5, 5, 1'b1, w);
         chk("R10 tied word", w, 8'h31 + k);
         chk("R10 released between", int'(bus_drive), 0);
      end
      chk("R10 drained", int'(empty_n), 0);

      // R7: short active pulse
      do_reset();
      push(0, 8'h41); push(0, 8'h42);
      cs_n = 1'b0; oe_n = 1'b0; tick(3);
      chk("R7 error clear before", int'(proto_err), 0);
      pulse(1, 6, 1'b0, w);
      chk("R7 error set", int'(proto_err), 1);
      chk("R7 no advance", int'(empty_n), 1);
      pulse(5, 5, 1'b0, w);
      chk("R7 same word again", w, 8'h41);
      pulse(5, 5, 1'b0, w);
      chk("R7 next word", w, 8'h42);
      chk("R7 error sticky", int'(proto_err), 1);

      // R8: inactive gap too short
      do_reset();
      push(0, 8'h51); push(0, 8'h52); push(0, 8'h53);
      cs_n = 1'b0; oe_n = 1'b0; tick(3);
      pulse(5, 1, 1'b0, w);
      chk("R8 first word", w, 8'h51);
      pulse(5, 5, 1'b0, w);
      chk("R8 refused pulse keeps word", w, 8'h51);
      chk("R8 error set", int'(proto_err), 1);
      pulse(5, 5, 1'b0, w);
      chk("R8 refused pulse consumed nothing", w, 8'h52);
      chk("R8 one word left", int'(empty_n), 1);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule